// File: doc/BRIEF.md
# Channel Interrupt Control and Status Register

This block is the interrupt register of one transfer channel. It keeps five interrupt enables and five sticky event flags in a single 32-bit word. Five completion and error pulses arrive from the channel's transfer engine: fragment finished, block finished, transaction finished, descriptor list finished, and configuration error. A pulse whose enable is set latches its flag. Software clears flags by writing ones to a separate field of clear strobes in the same word.

The block drives two interrupt lines. The raw line follows the flags. The masked line also takes the current enables into account. A third output reports when exactly one flag is pending, because the servicing software treats any other pattern as an invalid interrupt. The register answers at one address offset of the channel's register window. Writes and reads at any other offset leave it untouched and read as zero.

Top module: `chn_irq_ctrl`

## Requirements
- R1: After reset, all enables and flags are zero, both interrupt lines are low, and a read at the register offset returns zero.
- R2: A write at offset 0x0C loads the enables from bits 4:0 (fragment bit 0, block bit 1, transaction bit 2, list bit 3, configuration error bit 4). A read shows them at the same positions.
- R3: A pulse on event i while enable i is set sets flag i, which reads at bit 16+i, one cycle later.
- R4: A pulse on event i while enable i is clear is ignored: flag i stays as it was.
- R5: A flag stays set, with no further pulse, until it is cleared.
- R6: Writing a one to bit 24+i at the register offset clears flag i. A zero in that bit leaves flag i unchanged.
- R7: When a clear of flag i and an enabled pulse on event i fall in the same cycle, the flag ends up set.
- R8: A read returns zero in the clear field (bits 28:24) and in every unused bit.
- R9: Writes at any other offset change neither enables nor flags. Reads at any other offset return zero.
- R10: irqRaw is high exactly while at least one flag is set.
- R11: irqOut is high exactly while some flag is set and its enable is also set.
- R12: evtSingle is high exactly while one flag, and only one, is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe of the register bus |
| busAddr | input | 8 | Byte offset within the channel window |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| evtPulse | input | 5 | Event pulses from the engine, bit order as the enables |
| irqRaw | output | 1 | High while any flag is set |
| irqOut | output | 1 | High while any enabled flag is set |
| evtSingle | output | 1 | High while exactly one flag is set |

## Verification
A write and an event pulse are both captured at the same rising edge. Their effect on enables, flags and all three interrupt outputs is visible directly after that edge, and the read path adds no further delay because it is combinational from the current address. The bench therefore drives each stimulus for one cycle starting at a falling edge. It moves the address to the register offset on the next falling edge and samples one nanosecond later. Every result is checked exactly one edge after the stimulus that caused it. Sweeps cover every combination of enable mask and event mask, and every clear mask against a full set of flags.

// File: rtl/chn_irq_pkg.sv
package chn_irq_pkg;
  localparam int NUM_EVT = 5;

  typedef struct packed {
    logic               rdHit;
    logic               enLoad;
    logic [NUM_EVT-1:0] enVal;
    logic [NUM_EVT-1:0] clrMask;
  } irqStrobe_t;
endpackage

// File: rtl/chn_irq_decode.sv
module chn_irq_decode
  import chn_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h0C,
  parameter int EN_LSB  = 0,
  parameter int CLR_LSB = 24
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output irqStrobe_t        strb
);
  logic addrHit;
  logic unusedData;

  assign addrHit    = (busAddr == REG_OFS);
  assign unusedData = ^busWrData;

  always_comb begin
    strb.rdHit   = addrHit;
    strb.enLoad  = addrHit && busWrEn;
    strb.enVal   = busWrData[EN_LSB +: NUM_EVT];
    strb.clrMask = (addrHit && busWrEn) ? busWrData[CLR_LSB +: NUM_EVT] : '0;
  end
endmodule

// File: rtl/chn_irq_dp.sv
module chn_irq_dp
  import chn_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int EN_LSB  = 0,
  parameter int STS_LSB = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strb,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_EVT-1:0] enQ,
  output logic [NUM_EVT-1:0] stsQ,
  output logic               irqRaw,
  output logic               irqOut,
  output logic               evtSingle
);
  logic [NUM_EVT-1:0] stsNext;
  logic [NUM_EVT-1:0] setMask;

  assign setMask = evtPulse & enQ;
  assign stsNext = (stsQ & ~strb.clrMask) | setMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= '0;
      stsQ <= '0;
    end else begin
      if (strb.enLoad) enQ <= strb.enVal;
      stsQ <= stsNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdHit) begin
      rdData[EN_LSB +: NUM_EVT]  = enQ;
      rdData[STS_LSB +: NUM_EVT] = stsQ;
    end
  end

  assign irqRaw    = |stsQ;
  assign irqOut    = |(stsQ & enQ);
  assign evtSingle = (stsQ != '0) && ((stsQ & (stsQ - 1'b1)) == '0);
endmodule

// File: rtl/chn_irq_ctrl.sv
module chn_irq_ctrl
  import chn_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h0C,
  parameter int EN_LSB  = 0,
  parameter int STS_LSB = 16,
  parameter int CLR_LSB = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic               irqRaw,
  output logic               irqOut,
  output logic               evtSingle
);
  irqStrobe_t         strb;
  logic [NUM_EVT-1:0] enQ;
  logic [NUM_EVT-1:0] stsQ;

  chn_irq_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS),
    .EN_LSB(EN_LSB), .CLR_LSB(CLR_LSB)
  ) u_decode (
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .strb(strb)
  );

  chn_irq_dp #(
    .DATA_W(DATA_W), .EN_LSB(EN_LSB), .STS_LSB(STS_LSB)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtPulse(evtPulse),
    .rdData(busRdData), .enQ(enQ), .stsQ(stsQ),
    .irqRaw(irqRaw), .irqOut(irqOut), .evtSingle(evtSingle)
  );
endmodule

// File: rtl/chn_irq_ctrl_chk.sv
module chn_irq_ctrl_chk
  import chn_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h0C,
  parameter int EN_LSB  = 0,
  parameter int CLR_LSB = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWrEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWrData,
  input logic [DATA_W-1:0]  busRdData,
  input logic [NUM_EVT-1:0] evtPulse,
  input logic               irqRaw,
  input logic               irqOut,
  input logic [NUM_EVT-1:0] enQ,
  input logic [NUM_EVT-1:0] stsQ
);
  logic               wrHit;
  logic [NUM_EVT-1:0] clrSeen;
  logic               unusedChk;

  assign wrHit     = busWrEn && (busAddr == REG_OFS);
  assign clrSeen   = wrHit ? busWrData[CLR_LSB +: NUM_EVT] : '0;
  assign unusedChk = ^busWrData;

  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    ((stsQ & ~$past(stsQ)) & ~$past(evtPulse & enQ)) == '0); // R4

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    ($past(evtPulse & enQ) & ~stsQ) == '0); // R7

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(stsQ) & ~stsQ) & ~$past(clrSeen)) == '0); // R5

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && rstN) |=> (enQ == $past(busWrData[EN_LSB +: NUM_EVT]))); // R2

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[CLR_LSB +: NUM_EVT] == '0); // R8

  AST_MASKED_IMPLIES_RAW: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqRaw); // R11
endmodule

bind chn_irq_ctrl chn_irq_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS),
  .EN_LSB(EN_LSB), .CLR_LSB(CLR_LSB)
) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .evtPulse(evtPulse),
  .irqRaw(irqRaw), .irqOut(irqOut), .enQ(enQ), .stsQ(stsQ)
);

// File: tb/chn_irq_ctrl_tb.sv
`timescale 1ns/1ps
module chn_irq_ctrl_tb;
  localparam logic [7:0] OFS = 8'h0C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [4:0]  evtPulse = '0;
  logic        irqRaw, irqOut, evtSingle;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  chn_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .evtPulse(evtPulse),
    .irqRaw(irqRaw), .irqOut(irqOut), .evtSingle(evtSingle)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [7:0] addr,
                       input logic [31:0] data, input logic [4:0] evt);
    @(negedge clk);
    busWrEn = we; busAddr = addr; busWrData = data; evtPulse = evt;
    @(negedge clk);
    busWrEn = 1'b0; evtPulse = '0; busAddr = OFS;
    #1;
  endtask

  function automatic logic [31:0] word(input logic [4:0] en, input logic [4:0] sts);
    return {11'd0, sts, 11'd0, en};
  endfunction

  function automatic logic single(input logic [4:0] v);
    int n = 0;
    for (int i = 0; i < 5; i++) n += v[i];
    return n == 1;
  endfunction

  task automatic chkAll(input string req, input logic [4:0] en, input logic [4:0] sts);
    chk({req, " word"}, busRdData, word(en, sts));
    chk("R10 irqRaw", {31'd0, irqRaw}, {31'd0, sts != 0});
    chk("R11 irqOut", {31'd0, irqOut}, {31'd0, (sts & en) != 0});
    chk("R12 evtSingle", {31'd0, evtSingle}, {31'd0, single(sts)});
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    busAddr = OFS;
    #1;
    chkAll("R1 reset", 5'd0, 5'd0);

    for (int en = 0; en < 32; en++) begin
      for (int ev = 0; ev < 32; ev++) begin
        drive(1'b1, OFS, {3'd0, 5'h1F, 19'd0, 5'(en)}, 5'd0);
        drive(1'b0, OFS, 32'd0, 5'(ev));
        chkAll("R2 R3 R4", 5'(en), 5'(en & ev));
      end
    end

    for (int c = 0; c < 32; c++) begin
      drive(1'b1, OFS, {3'd0, 5'h1F, 19'd0, 5'h1F}, 5'd0);
      drive(1'b0, OFS, 32'd0, 5'h1F);
      drive(1'b1, OFS, {3'h7, 5'(c), 8'hFF, 3'd0, 8'hFF, 5'h1F}, 5'd0);
      chkAll("R6 R8", 5'h1F, 5'(~c));
    end

    for (int i = 0; i < 5; i++) begin
      drive(1'b1, OFS, {3'd0, 5'h1F, 19'd0, 5'h1F}, 5'd0);
      drive(1'b1, OFS, {3'd0, 5'h1F, 19'd0, 5'h1F}, 5'(1 << i));
      chkAll("R7 set wins", 5'h1F, 5'(1 << i));
    end

    drive(1'b0, OFS, 32'd0, 5'h05);
    repeat (4) @(negedge clk);
    #1;
    chkAll("R5 sticky", 5'h1F, 5'h15);

    drive(1'b1, OFS, 32'd0, 5'd0);
    chkAll("R11 enables dropped", 5'd0, 5'h15);
    drive(1'b0, OFS, 32'd0, 5'h1F);
    chkAll("R4 ignored", 5'd0, 5'h15);

    drive(1'b1, 8'h08, 32'hFFFF_FFFF, 5'd0);
    chkAll("R9 other write", 5'd0, 5'h15);
    busAddr = 8'h10;
    #1;
    chk("R9 other read", busRdData, 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule